// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Controller

This block is a first-in first-out buffer with independent write and read clocks. Words enter on `din` when `wr_en` is high at a write-clock edge and leave on `dout` under `rd_en` at a read-clock edge. The storage is a behavioural register array of `2**ADDR_W` words. Binary pointers are kept in their own clock domains. Each pointer is turned into Gray code in a register and crosses to the other domain through a synchronizer of `SYNC_STAGES` flops, where it is decoded back to binary.

Two output disciplines exist, and the choice is latched from `fwft_sel` while master reset is held. In standard mode a read enable fetches the next word into the output register. In fall-through mode (FWFT) the oldest word is moved into the output register on its own, and a read enable consumes it. The meaning of the two main status pins follows the latched mode. A fixed half-full flag and two programmable threshold flags are valid in either mode. Their offsets are latched from `ae_off` and `af_off` at master reset.

Partial reset empties the buffer but keeps the mode and the offsets. Retransmit rewinds the read side to the first location so that stored words can be read again.

Top module: `dm_fifo`

## Requirements
- R1: In standard mode (latched `fwft_sel`=0), words are read in write order. A read with `rd_en`=1 loads the next word into `dout` at that read-clock edge. `rd_flag_n` is 0 exactly when no word is stored. `wr_flag_n` is 0 exactly when `2**ADDR_W` words are stored. The write pointer advances by at most one per write-clock edge.
- R2: In fall-through mode (latched `fwft_sel`=1), the oldest word appears on `dout` without any read enable. `rd_flag_n` is 0 while a word is presented. A read consumes the presented word, and the next word is presented at that same edge. `wr_flag_n` is 0 while the array has space. The array plus the output register hold `2**ADDR_W + 1` words.
- R3: The mode is taken from `fwft_sel` only while `mrst_n` is 0. At all other times a change on `fwft_sel` has no effect.
- R4: `hf_n` is 0 exactly when the write-side count of stored words is greater than `2**(ADDR_W-1)`.
- R5: `pae_n` is 0 exactly when the read-side count is less than or equal to the almost-empty offset. In fall-through mode the read-side count includes the presented word.
- R6: `paf_n` is 0 exactly when the write-side count is at least `2**ADDR_W` minus the almost-full offset.
- R7: The almost-empty and almost-full offsets are taken from `ae_off` and `af_off` while `mrst_n` is 0, and only then.
- R8: A write while the buffer is full is ignored. Neither the write pointer nor the stored data changes.
- R9: A read while nothing is stored is ignored, and the read pointer does not move.
- R10: Master reset returns both pointers to the first location. After it, `rd_flag_n`=0, `wr_flag_n`=1, `hf_n`=1, `pae_n`=0 and `paf_n`=1 in standard mode. In fall-through mode `rd_flag_n`=1 and `wr_flag_n`=0.
- R11: Partial reset (`prst_n`=0) returns both pointers to the first location and discards the stored words. It keeps the latched mode and both latched offsets.
- R12: `rt_n`=0 at a read-clock edge sets the read pointer to the first location and drops any presented word. A read enable at the same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, synchronous in each domain |
| fwft_sel | input | 1 | Mode select latched at master reset (1 = fall-through) |
| ae_off | input | ADDR_W | Almost-empty offset, latched at master reset |
| af_off | input | ADDR_W | Almost-full offset, latched at master reset |
| wr_en | input | 1 | Write enable, active high |
| din | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable, active high |
| rt_n | input | 1 | Retransmit, active low, sampled on the read clock |
| dout | output | DATA_W | Output data register |
| rd_flag_n | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active low |
| wr_flag_n | output | 1 | Full flag (standard) or input-ready flag (fall-through), active low |
| hf_n | output | 1 | Half-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
The retransmit rewind and an ordinary read can fall on the same read-clock edge. The bench provokes this by holding `rt_n` low and `rd_en` high together for one edge, after two of four stored words have been read. The result is judged by the words read next: the rewind must win, so four reads must return the four words from the first onward, and the almost-empty flag must show the full count.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fifo_mode_e;
endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_gray_xfer.sv
module dmf_gray_xfer #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          src_clk,
   input  logic          dst_clk,
   input  logic          rst_n,
   input  logic [PW-1:0] src_bin,
   output logic [PW-1:0] dst_bin
);
   logic [PW-1:0]              gray_src;
   logic [STAGES-1:0][PW-1:0] stg;
   logic [PW-1:0]              gray_dst;

   // registered Gray code: one bit changes per increment, no glitches
   always_ff @(posedge src_clk) begin
      if (!rst_n) gray_src <= '0;
      else        gray_src <= src_bin ^ (src_bin >> 1);
   end

   always_ff @(posedge dst_clk) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], gray_src};
   end

   assign gray_dst = stg[STAGES-1];

   // each binary bit is the parity of the Gray bits at and above it
   for (genvar i = 0; i < PW; i++) begin : g_dec
      assign dst_bin[i] = ^gray_dst[PW-1:i];
   end
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl
   import dmf_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          mode_sel,
   input  logic [AW-1:0] af_off,
   input  logic          wr_en,
   input  logic [AW:0]   rd_bin,
   output logic [AW:0]   wptr,
   output logic          mem_we,
   output logic          full,
   output fifo_mode_e    mode_q,
   output logic          wr_flag_n,
   output logic          hf_n,
   output logic          paf_n
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);
   localparam logic [AW:0]   HALF_V  = (AW+1)'(DEPTH / 2);
   localparam logic [AW+1:0] DEPTH_W = (AW+2)'(DEPTH);

   logic [AW-1:0] af_q;
   logic [AW:0]   wr_cnt;
   logic [AW+1:0] paf_sum;

   assign wr_cnt  = wptr - rd_bin;
   assign full    = (wr_cnt == DEPTH_V);
   assign mem_we  = wr_en && !full && mrst_n && prst_n;
   assign paf_sum = {1'b0, wr_cnt} + {2'b00, af_q};

   always_ff @(posedge wclk) begin
      if (!mrst_n) begin
         wptr   <= '0;
         mode_q <= fifo_mode_e'(mode_sel);
         af_q   <= af_off;
      end else if (!prst_n) begin
         wptr <= '0;
      end else if (wr_en && !full) begin
         wptr <= wptr + 1'b1;
      end
   end

   // standard: low when full; fall-through: low while there is space
   assign wr_flag_n = (mode_q == MODE_FWFT) ? full : !full;
   assign hf_n      = !(wr_cnt > HALF_V);
   assign paf_n     = !(paf_sum >= DEPTH_W);
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
   import dmf_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          mode_sel,
   input  logic [AW-1:0] ae_off,
   input  logic          rd_en,
   input  logic          rt_n,
   input  logic [AW:0]   wr_bin,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW:0]   rptr,
   output logic          mem_ne,
   output fifo_mode_e    mode_q,
   output logic [DW-1:0] dout,
   output logic          rd_flag_n,
   output logic          pae_n
);
   logic [AW-1:0] ae_q;
   logic          ovalid;
   logic [AW:0]   mem_cnt;
   logic [AW+1:0] rd_cnt;
   logic          fwft;
   logic          take;

   assign fwft    = (mode_q == MODE_FWFT);
   assign mem_cnt = wr_bin - rptr;
   assign mem_ne  = (mem_cnt != '0);
   assign take    = mem_ne && (!ovalid || rd_en);
   assign rd_cnt  = {1'b0, mem_cnt} + {{(AW+1){1'b0}}, (fwft && ovalid)};

   always_ff @(posedge rclk) begin
      if (!mrst_n) begin
         rptr   <= '0;
         ovalid <= 1'b0;
         dout   <= '0;
         mode_q <= fifo_mode_e'(mode_sel);
         ae_q   <= ae_off;
      end else if (!prst_n || !rt_n) begin
         rptr   <= '0;
         ovalid <= 1'b0;
      end else if (fwft) begin
         if (take) begin
            dout   <= mem_rdata;
            rptr   <= rptr + 1'b1;
            ovalid <= 1'b1;
         end else if (rd_en && ovalid) begin
            ovalid <= 1'b0;
         end
      end else if (rd_en && mem_ne) begin
         dout <= mem_rdata;
         rptr <= rptr + 1'b1;
      end
   end

   // standard: low when nothing stored; fall-through: low while a word is shown
   assign rd_flag_n = fwft ? !ovalid : mem_ne;
   assign pae_n     = !(rd_cnt <= {2'b00, ae_q});
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo
   import dmf_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic [ADDR_W-1:0] ae_off,
   input  logic [ADDR_W-1:0] af_off,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_en,
   input  logic              rt_n,
   output logic [DATA_W-1:0] dout,
   output logic              rd_flag_n,
   output logic              wr_flag_n,
   output logic              hf_n,
   output logic              pae_n,
   output logic              paf_n
);
   localparam int PW = ADDR_W + 1;

   if (DATA_W < 1)      begin : g_bad_dw  $error("DATA_W must be at least 1");      end
   if (ADDR_W < 2)      begin : g_bad_aw  $error("ADDR_W must be at least 2");      end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end

   logic              rst_n;
   logic [PW-1:0]     w_ptr, r_ptr, w_bin_r, r_bin_w;
   logic              w_full, r_ne, mem_we;
   logic [DATA_W-1:0] mem_rdata;
   fifo_mode_e        w_mode, r_mode;

   assign rst_n = mrst_n & prst_n;

   dmf_store #(.DW(DATA_W), .AW(ADDR_W)) u_store (
      .wclk (wclk), .we (mem_we), .waddr (w_ptr[ADDR_W-1:0]), .wdata (din),
      .raddr (r_ptr[ADDR_W-1:0]), .rdata (mem_rdata)
   );

   dmf_gray_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .src_clk (wclk), .dst_clk (rclk), .rst_n (rst_n),
      .src_bin (w_ptr), .dst_bin (w_bin_r)
   );

   dmf_gray_xfer #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .src_clk (rclk), .dst_clk (wclk), .rst_n (rst_n),
      .src_bin (r_ptr), .dst_bin (r_bin_w)
   );

   dmf_wr_ctl #(.AW(ADDR_W)) u_wr (
      .wclk (wclk), .mrst_n (mrst_n), .prst_n (prst_n), .mode_sel (fwft_sel),
      .af_off (af_off), .wr_en (wr_en), .rd_bin (r_bin_w), .wptr (w_ptr),
      .mem_we (mem_we), .full (w_full), .mode_q (w_mode),
      .wr_flag_n (wr_flag_n), .hf_n (hf_n), .paf_n (paf_n)
   );

   dmf_rd_ctl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
      .rclk (rclk), .mrst_n (mrst_n), .prst_n (prst_n), .mode_sel (fwft_sel),
      .ae_off (ae_off), .rd_en (rd_en), .rt_n (rt_n), .wr_bin (w_bin_r),
      .mem_rdata (mem_rdata), .rptr (r_ptr), .mem_ne (r_ne), .mode_q (r_mode),
      .dout (dout), .rd_flag_n (rd_flag_n), .pae_n (pae_n)
   );
endmodule

// File: rtl/dm_fifo_chk.sv
module dm_fifo_chk #(
   parameter int AW = 4
) (
   input logic        wclk,
   input logic        rclk,
   input logic        mrst_n,
   input logic        prst_n,
   input logic        wr_en,
   input logic        rt_n,
   input logic        w_full,
   input logic        r_ne,
   input logic [AW:0] w_ptr,
   input logic [AW:0] r_ptr,
   input logic        hf_n,
   input logic        paf_n,
   input logic        w_mode,
   input logic        r_mode
);
   p_no_overflow_r8: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
      (w_full && wr_en) |=> (w_ptr == $past(w_ptr)));

   p_wptr_step_r1: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
      (w_ptr == $past(w_ptr)) || (w_ptr == $past(w_ptr) + 1'b1));

   p_no_underflow_r9: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
      (!r_ne && rt_n) |=> (r_ptr == $past(r_ptr)));

   p_rt_rewind_r12: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
      !rt_n |=> (r_ptr == '0));

   p_full_half_r4: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
      w_full |-> !hf_n);

   p_full_almost_r6: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
      w_full |-> !paf_n);

   p_wmode_kept_r11: assert property (@(posedge wclk) disable iff (!mrst_n)
      $stable(w_mode));

   p_rmode_kept_r3: assert property (@(posedge rclk) disable iff (!mrst_n)
      $stable(r_mode));
endmodule

bind dm_fifo dm_fifo_chk #(.AW(ADDR_W)) u_chk (
   .wclk (wclk), .rclk (rclk), .mrst_n (mrst_n), .prst_n (prst_n),
   .wr_en (wr_en), .rt_n (rt_n), .w_full (w_full), .r_ne (r_ne),
   .w_ptr (w_ptr), .r_ptr (r_ptr), .hf_n (hf_n), .paf_n (paf_n),
   .w_mode (w_mode), .r_mode (r_mode)
);

// File: tb/dm_fifo_tb.sv
module dm_fifo_tb;
   localparam int DW = 8;
   localparam int AW = 4;

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
   logic [AW-1:0] ae_off = 4'd2, af_off = 4'd3;
   logic          wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          rd_flag_n, wr_flag_n, hf_n, pae_n, paf_n;

   int checks = 0;
   int fails  = 0;

   always #10 wclk = ~wclk;
   initial begin
      #3;
      forever #10 rclk = ~rclk;
   end

   dm_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .wclk (wclk), .rclk (rclk), .mrst_n (mrst_n), .prst_n (prst_n),
      .fwft_sel (fwft_sel), .ae_off (ae_off), .af_off (af_off),
      .wr_en (wr_en), .din (din), .rd_en (rd_en), .rt_n (rt_n),
      .dout (dout), .rd_flag_n (rd_flag_n), .wr_flag_n (wr_flag_n),
      .hf_n (hf_n), .pae_n (pae_n), .paf_n (paf_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge wclk);
      repeat (6) @(negedge rclk);
   endtask

   task automatic do_mrst(input logic mode, input logic [AW-1:0] ae, input logic [AW-1:0] af);
      @(negedge wclk);
      mrst_n = 1'b0; fwft_sel = mode; ae_off = ae; af_off = af;
      repeat (4) @(negedge wclk);
      mrst_n = 1'b1;
      settle();
   endtask

   task automatic do_prst();
      @(negedge wclk);
      prst_n = 1'b0;
      repeat (4) @(negedge wclk);
      prst_n = 1'b1;
      settle();
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge wclk);
      wr_en = 1'b1; din = d;
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic pop(output logic [DW-1:0] d);
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      d = dout;
   endtask

   task automatic t_reset_std();
      do_mrst(1'b0, 4'd2, 4'd3);
      chk("R10 rd_flag_n", rd_flag_n, 0);
      chk("R10 wr_flag_n", wr_flag_n, 1);
      chk("R10 hf_n", hf_n, 1);
      chk("R10 pae_n", pae_n, 0);
      chk("R10 paf_n", paf_n, 1);
   endtask

   task automatic t_order_std();
      logic [DW-1:0] d;
      for (int i = 0; i < 5; i++) push(8'h10 + DW'(i));
      settle();
      chk("R1 not empty", rd_flag_n, 1);
      chk("R5 pae_n above offset", pae_n, 1);
      for (int i = 0; i < 5; i++) begin
         pop(d);
         chk("R1 read order", d, 8'h10 + DW'(i));
      end
      settle();
      chk("R1 empty again", rd_flag_n, 0);
   endtask

   task automatic t_levels_full();
      logic [DW-1:0] d;
      do_mrst(1'b0, 4'd2, 4'd3);
      for (int n = 1; n <= 16; n++) begin
         push(DW'(n));
         settle();
         if (n == 2)  chk("R5 pae_n at offset", pae_n, 0);
         if (n == 3)  chk("R5 pae_n past offset", pae_n, 1);
         if (n == 8)  chk("R4 hf_n at half", hf_n, 1);
         if (n == 9)  chk("R4 hf_n over half", hf_n, 0);
         if (n == 12) chk("R6 paf_n below", paf_n, 1);
         if (n == 13) chk("R6 paf_n at threshold", paf_n, 0);
         if (n == 15) chk("R1 not full", wr_flag_n, 1);
         if (n == 16) chk("R1 full", wr_flag_n, 0);
      end
      push(8'hEE);
      settle();
      for (int i = 1; i <= 16; i++) begin
         pop(d);
         chk("R8 data after write on full", d, DW'(i));
      end
      settle();
      chk("R8 no extra word", rd_flag_n, 0);
   endtask

   task automatic t_empty_read();
      logic [DW-1:0] d;
      pop(d);
      pop(d);
      push(8'h5A);
      settle();
      pop(d);
      chk("R9 read on empty ignored", d, 8'h5A);
      settle();
      chk("R9 empty after one", rd_flag_n, 0);
   endtask

   task automatic t_retransmit();
      logic [DW-1:0] d;
      do_mrst(1'b0, 4'd2, 4'd3);
      for (int i = 0; i < 4; i++) push(8'h21 + DW'(i));
      settle();
      pop(d);
      pop(d);
      chk("R12 before rewind", d, 8'h22);
      @(negedge rclk);
      rt_n = 1'b0; rd_en = 1'b1;
      @(negedge rclk);
      rt_n = 1'b1; rd_en = 1'b0;
      settle();
      chk("R12 count restored", pae_n, 1);
      for (int i = 0; i < 4; i++) begin
         pop(d);
         chk("R12 reread", d, 8'h21 + DW'(i));
      end
      settle();
      chk("R12 empty after reread", rd_flag_n, 0);
   endtask

   task automatic t_partial();
      logic [DW-1:0] d;
      do_mrst(1'b0, 4'd2, 4'd3);
      push(8'h31);
      push(8'h32);
      settle();
      fwft_sel = 1'b1; ae_off = 4'd6; af_off = 4'd9;
      do_prst();
      chk("R11 emptied, mode kept", rd_flag_n, 0);
      chk("R3 mode kept wr side", wr_flag_n, 1);
      for (int i = 0; i < 3; i++) push(8'h41 + DW'(i));
      settle();
      chk("R11 ae offset kept", pae_n, 1);
      for (int i = 3; i < 7; i++) push(8'h41 + DW'(i));
      settle();
      chk("R7 af offset kept", paf_n, 1);
      pop(d);
      chk("R11 old words gone", d, 8'h41);
      fwft_sel = 1'b0; ae_off = 4'd2; af_off = 4'd3;
   endtask

   task automatic t_fwft();
      logic [DW-1:0] d;
      do_mrst(1'b1, 4'd1, 4'd2);
      chk("R10 fwft rd_flag_n", rd_flag_n, 1);
      chk("R10 fwft wr_flag_n", wr_flag_n, 0);
      for (int i = 0; i < 3; i++) push(8'h51 + DW'(i));
      settle();
      chk("R2 word ready", rd_flag_n, 0);
      chk("R2 fall-through data", dout, 8'h51);
      chk("R5 fwft pae_n with 3", pae_n, 1);
      pop(d);
      chk("R2 next word shown", d, 8'h52);
      pop(d);
      chk("R2 last word shown", d, 8'h53);
      settle();
      chk("R5 fwft pae_n with 1", pae_n, 0);
      pop(d);
      settle();
      chk("R2 nothing ready", rd_flag_n, 1);
   endtask

   task automatic t_fwft_capacity();
      logic [DW-1:0] d;
      do_mrst(1'b1, 4'd1, 4'd2);
      for (int i = 0; i < 16; i++) push(8'h60 + DW'(i));
      settle();
      chk("R2 ready with 16", wr_flag_n, 0);
      push(8'h70);
      settle();
      chk("R2 not ready with 17", wr_flag_n, 1);
      chk("R2 head word", dout, 8'h60);
      for (int i = 1; i <= 16; i++) begin
         pop(d);
         chk("R2 drain order", d, 8'h60 + DW'(i));
      end
   endtask

   initial begin
      repeat (100000) @(posedge wclk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset_std();
      t_order_std();
      t_levels_full();
      t_empty_read();
      t_retransmit();
      t_partial();
      t_fwft();
      t_fwft_capacity();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule